// File: doc/BRIEF.md
# Multi-Channel Compare-Match Event Timer

A register-mapped timer with one 64-bit up-counter that all comparator channels share. Each channel holds a 32-bit match value. It raises its interrupt output when the running counter reaches that value. A channel is either single-shot, firing once per programmed value, or repeating. In repeating mode a stored interval is added to the match value on every hit, so interrupts keep arriving with no software involvement.

Software reaches the block over a plain 32-bit word bus: word address, write strobe, write data, and a combinational read-data return. Two read-only words describe the instance (channel count, counter width, tick length in femtoseconds). One word gates the counter. One word collects the latched flags of level-type channels and clears them on a write of one. Each channel has a control word and a match word. The channel count, the address width, the tick length and which channels can repeat are all parameters.

Top module: `evt_timer`

## Requirements
- R1: Word 0 reads channel count minus one in bits [4:0] and a one in bit 8 (the counter is 64 bits wide), so 0x102 for three channels. Word 1 reads the tick length parameter. Writes to both words change nothing.
- R2: While bit 0 of word 2 is set, the counter (low half at word 4, high half at word 5) grows by exactly one per clock. While that bit is clear, the counter holds.
- R3: Writes to word 4 or 5 load that half of the counter only while the counter is stopped. While it runs, such writes are ignored.
- R4: A channel hits in a clock where the counter is running and its low 32 bits equal the match word. Unless control bit 4 (low-half-only compare) is set, the upper 32 counter bits must also be zero. A stopped counter never hits.
- R5: A single-shot channel hits once, and its match word keeps the written value afterwards.
- R6: With control bit 2 (repeat) and bit 5 (load-match) set, the next match-word write sets the match point and clears bit 5. Later match-word writes set the interval. Each hit then advances the match word by the interval, so hits recur every interval clocks.
- R7: On a channel without repeat capability (control bit 3 reads 0), writing bit 2 has no effect. It reads back 0 and match-word writes still load the match point.
- R8: A hit on a level-type channel (control bit 0 = 1) sets bit n of word 3, where n is the channel index. Writing 1 to that bit clears it, and writing 0 leaves it. A hit in the same clock as the clear keeps the bit set.
- R9: With control bit 1 (enable) set, a level channel drives its interrupt high while its flag in word 3 is set. An edge channel (bit 0 = 0) drives a single-clock pulse in the clock after its hit.
- R10: Words 6, 7 and every word past the last channel read zero. Reads have no side effects, and the counter keeps running during them.
- R11: After reset all control, match, flag and counter state is zero and every interrupt output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | ADDR_W | Word address |
| busWe | input | 1 | Write strobe for the addressed word |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for the addressed word (combinational) |
| irq | output | NUM_CH | Per-channel interrupt outputs |

## Verification
The bench tries a single-shot edge channel, a repeating edge channel, a level channel without repeat capability, and a low-half-only channel. Together these separate one-time firing from periodic reload, and pulse output from held output. Counter loads are tried both while stopped and while running, which tells gated writes apart from unconditional ones. A match value equal to a stopped counter shows that hits need a running counter. A counter with a nonzero upper half shows the difference between full-width and low-half compares. Writes of zero and of one to the flag word, including bits that are already clear, separate write-one-to-clear from plain overwrite.

// File: rtl/et_pkg.sv
package et_pkg;
  localparam int DATA_W   = 32;
  localparam int CNT_W    = 64;
  localparam int CH_IDX_W = 3;

  localparam int A_CAPINFO = 0;
  localparam int A_CAPTICK = 1;
  localparam int A_GCFG    = 2;
  localparam int A_STAT    = 3;
  localparam int A_CNTLO   = 4;
  localparam int A_CNTHI   = 5;
  localparam int A_CHBASE  = 8;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_CAPINFO, SEL_CAPTICK, SEL_GCFG, SEL_STAT,
    SEL_CNTLO, SEL_CNTHI, SEL_CHCFG, SEL_CHCMP
  } rdSel_e;

  typedef struct packed {
    logic                wrGcfg;
    logic                wrStat;
    logic                wrCntLo;
    logic                wrCntHi;
    logic                wrChCfg;
    logic                wrChCmp;
    logic [CH_IDX_W-1:0] chIdx;
    rdSel_e              rdSel;
  } strobe_t;
endpackage

// File: rtl/et_ctrl.sv
module et_ctrl
  import et_pkg::*;
#(
  parameter int NUM_CH = 3,
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  output strobe_t           strb
);
  always_comb begin
    strb = '0;
    strb.rdSel = SEL_NONE;
    if (busAddr == ADDR_W'(A_CAPINFO)) begin
      strb.rdSel = SEL_CAPINFO;
    end else if (busAddr == ADDR_W'(A_CAPTICK)) begin
      strb.rdSel = SEL_CAPTICK;
    end else if (busAddr == ADDR_W'(A_GCFG)) begin
      strb.rdSel  = SEL_GCFG;
      strb.wrGcfg = busWe;
    end else if (busAddr == ADDR_W'(A_STAT)) begin
      strb.rdSel  = SEL_STAT;
      strb.wrStat = busWe;
    end else if (busAddr == ADDR_W'(A_CNTLO)) begin
      strb.rdSel   = SEL_CNTLO;
      strb.wrCntLo = busWe;
    end else if (busAddr == ADDR_W'(A_CNTHI)) begin
      strb.rdSel   = SEL_CNTHI;
      strb.wrCntHi = busWe;
    end
    for (int i = 0; i < NUM_CH; i++) begin
      if (busAddr == ADDR_W'(A_CHBASE + 2 * i)) begin
        strb.rdSel   = SEL_CHCFG;
        strb.chIdx   = CH_IDX_W'(i);
        strb.wrChCfg = busWe;
      end
      if (busAddr == ADDR_W'(A_CHBASE + 2 * i + 1)) begin
        strb.rdSel   = SEL_CHCMP;
        strb.chIdx   = CH_IDX_W'(i);
        strb.wrChCmp = busWe;
      end
    end
  end
endmodule

// File: rtl/et_channel.sv
module et_channel
  import et_pkg::*;
#(
  parameter bit PER_CAP = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [CNT_W-1:0]  cntVal,
  input  logic              cntEn,
  input  logic              wrCfg,
  input  logic              wrCmp,
  input  logic [DATA_W-1:0] wdata,
  input  logic              statusBit,
  output logic [DATA_W-1:0] cfgRd,
  output logic [DATA_W-1:0] cmpRd,
  output logic              levelHit,
  output logic              irqOut
);
  logic              levelType, intEn, perSel, force32, setVal, pulse;
  logic [DATA_W-1:0] cmpVal, periodVal;
  logic              lowEq, highZero, hit;

  assign lowEq    = (cntVal[DATA_W-1:0] == cmpVal);
  assign highZero = (cntVal[CNT_W-1:DATA_W] == '0);
  assign hit      = cntEn && lowEq && (force32 || highZero);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      levelType <= 1'b0;
      intEn     <= 1'b0;
      perSel    <= 1'b0;
      force32   <= 1'b0;
      setVal    <= 1'b0;
      cmpVal    <= '0;
      periodVal <= '0;
      pulse     <= 1'b0;
    end else begin
      pulse <= hit && !levelType && intEn;
      if (wrCfg) begin
        levelType <= wdata[0];
        intEn     <= wdata[1];
        perSel    <= wdata[2] & PER_CAP;
        force32   <= wdata[4];
        setVal    <= wdata[5];
      end
      if (wrCmp) begin
        if (!perSel || setVal) cmpVal <= wdata;
        else                   periodVal <= wdata;
        setVal <= 1'b0;
      end else if (hit && perSel) begin
        cmpVal <= cmpVal + periodVal;
      end
    end
  end

  assign cfgRd    = {26'b0, setVal, force32, PER_CAP, perSel, intEn, levelType};
  assign cmpRd    = cmpVal;
  assign levelHit = hit && levelType;
  assign irqOut   = levelType ? (statusBit && intEn) : pulse;
endmodule

// File: rtl/et_datapath.sv
module et_datapath
  import et_pkg::*;
#(
  parameter int          NUM_CH       = 3,
  parameter logic [31:0] TICK_FS      = 32'd69841279,
  parameter logic [7:0]  PER_CAP_MASK = 8'h05
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [NUM_CH-1:0] irq,
  output logic [CNT_W-1:0]  cntOut,
  output logic              enOut,
  output logic [NUM_CH-1:0] statusOut,
  output logic [NUM_CH-1:0] levelHitOut
);
  localparam logic [DATA_W-1:0] CAP_INFO =
    DATA_W'({(CNT_W > DATA_W), 3'b000, 5'(NUM_CH - 1)});

  logic [CNT_W-1:0]  cnt;
  logic              gEn;
  logic [NUM_CH-1:0] status, levelHit;
  logic [DATA_W-1:0] chCfgRd [NUM_CH];
  logic [DATA_W-1:0] chCmpRd [NUM_CH];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt <= '0;
      gEn <= 1'b0;
    end else begin
      if (gEn) begin
        cnt <= cnt + 1'b1;
      end else begin
        if (strb.wrCntLo) cnt[DATA_W-1:0]     <= wdata;
        if (strb.wrCntHi) cnt[CNT_W-1:DATA_W] <= wdata;
      end
      if (strb.wrGcfg) gEn <= wdata[0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) status <= '0;
    else status <= (status & ~(strb.wrStat ? wdata[NUM_CH-1:0] : '0)) | levelHit;
  end

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    et_channel #(.PER_CAP(PER_CAP_MASK[i])) u_ch (
      .clk      (clk),
      .rstN     (rstN),
      .cntVal   (cnt),
      .cntEn    (gEn),
      .wrCfg    (strb.wrChCfg && (strb.chIdx == CH_IDX_W'(i))),
      .wrCmp    (strb.wrChCmp && (strb.chIdx == CH_IDX_W'(i))),
      .wdata    (wdata),
      .statusBit(status[i]),
      .cfgRd    (chCfgRd[i]),
      .cmpRd    (chCmpRd[i]),
      .levelHit (levelHit[i]),
      .irqOut   (irq[i])
    );
  end

  always_comb begin
    rdata = '0;
    case (strb.rdSel)
      SEL_CAPINFO: rdata = CAP_INFO;
      SEL_CAPTICK: rdata = TICK_FS;
      SEL_GCFG:    rdata = {31'b0, gEn};
      SEL_STAT:    rdata = DATA_W'(status);
      SEL_CNTLO:   rdata = cnt[DATA_W-1:0];
      SEL_CNTHI:   rdata = cnt[CNT_W-1:DATA_W];
      SEL_CHCFG: begin
        for (int i = 0; i < NUM_CH; i++)
          if (strb.chIdx == CH_IDX_W'(i)) rdata = chCfgRd[i];
      end
      SEL_CHCMP: begin
        for (int i = 0; i < NUM_CH; i++)
          if (strb.chIdx == CH_IDX_W'(i)) rdata = chCmpRd[i];
      end
      default: rdata = '0;
    endcase
  end

  assign cntOut      = cnt;
  assign enOut       = gEn;
  assign statusOut   = status;
  assign levelHitOut = levelHit;
endmodule

// File: rtl/evt_timer.sv
module evt_timer
  import et_pkg::*;
#(
  parameter int          NUM_CH       = 3,
  parameter int          ADDR_W       = 8,
  parameter logic [31:0] TICK_FS      = 32'd69841279,
  parameter logic [7:0]  PER_CAP_MASK = 8'h05
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  output logic [NUM_CH-1:0] irq
);
  strobe_t           strb;
  logic [CNT_W-1:0]  cntVal;
  logic              cntEn;
  logic [NUM_CH-1:0] statusVec, levelHitVec;

  et_ctrl #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_ctrl (
    .busAddr(busAddr),
    .busWe  (busWe),
    .strb   (strb)
  );

  et_datapath #(
    .NUM_CH(NUM_CH), .TICK_FS(TICK_FS), .PER_CAP_MASK(PER_CAP_MASK)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .wdata      (busWdata),
    .rdata      (busRdata),
    .irq        (irq),
    .cntOut     (cntVal),
    .enOut      (cntEn),
    .statusOut  (statusVec),
    .levelHitOut(levelHitVec)
  );
endmodule

// File: rtl/evt_timer_chk.sv
module evt_timer_chk
  import et_pkg::*;
#(
  parameter int NUM_CH = 3,
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busWe,
  input logic [31:0]       busWdata,
  input logic [31:0]       busRdata,
  input logic [CNT_W-1:0]  cntVal,
  input logic              cntEn,
  input logic [NUM_CH-1:0] statusVec,
  input logic [NUM_CH-1:0] levelHitVec
);
  logic cntWr, statWr, unmapped;
  assign cntWr    = busWe && (busAddr == ADDR_W'(A_CNTLO) || busAddr == ADDR_W'(A_CNTHI));
  assign statWr   = busWe && (busAddr == ADDR_W'(A_STAT));
  assign unmapped = (busAddr == ADDR_W'(6)) || (busAddr == ADDR_W'(7)) ||
                    (busAddr >= ADDR_W'(A_CHBASE + 2 * NUM_CH));

  p_count_step_r2: assert property (@(posedge clk) disable iff (!rstN)
    $past(cntEn) |-> cntVal == $past(cntVal) + 64'd1);

  p_count_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(cntEn) && !$past(cntWr)) |-> $stable(cntVal));

  p_hit_needs_run_r4: assert property (@(posedge clk) disable iff (!rstN)
    (|levelHitVec) |-> cntEn);

  p_flag_set_r8: assert property (@(posedge clk) disable iff (!rstN)
    ($past(levelHitVec) & ~statusVec) == '0);

  p_flag_clear_r8: assert property (@(posedge clk) disable iff (!rstN)
    $past(statWr) |-> (statusVec & $past(busWdata[NUM_CH-1:0]) & ~$past(levelHitVec)) == '0);

  p_flag_sticky_r8: assert property (@(posedge clk) disable iff (!rstN)
    (|($past(statusVec) & ~statusVec)) |-> $past(statWr));

  p_unmapped_zero_r10: assert property (@(posedge clk) disable iff (!rstN)
    unmapped |-> busRdata == 32'd0);
endmodule

bind evt_timer evt_timer_chk #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .busAddr    (busAddr),
  .busWe      (busWe),
  .busWdata   (busWdata),
  .busRdata   (busRdata),
  .cntVal     (cntVal),
  .cntEn      (cntEn),
  .statusVec  (statusVec),
  .levelHitVec(levelHitVec)
);

// File: tb/sim_evt_timer.sv
module sim_evt_timer;
  localparam int          CLK_PERIOD = 10;
  localparam int          NCH        = 3;
  localparam logic [31:0] TICK       = 32'd69841279;
  localparam logic [7:0]  CAPM       = 8'h05;
  localparam int          WATCHDOG   = 20000;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic [7:0]      busAddr = 8'd0;
  logic            busWe = 1'b0;
  logic [31:0]     busWdata = 32'd0;
  logic [31:0]     busRdata;
  logic [NCH-1:0]  irq;

  int nChecks = 0;
  int nFail   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  evt_timer #(.NUM_CH(NCH), .ADDR_W(8), .TICK_FS(TICK), .PER_CAP_MASK(CAPM)) u0 (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe),
    .busWdata(busWdata), .busRdata(busRdata), .irq(irq)
  );

  // ---------------- behavioural reference model ----------------
  bit [63:0] mCnt;
  bit        mEn;
  bit [NCH-1:0] mStat;
  bit        mLvl[NCH], mIe[NCH], mPerOn[NCH], mF32[NCH], mSv[NCH], mPulse[NCH], hitA[NCH];
  bit [31:0] mCmp[NCH], mPeriod[NCH];

  always @(posedge clk) begin
    if (!rstN) begin
      mCnt = 0; mEn = 0; mStat = 0;
      for (int c = 0; c < NCH; c++) begin
        mLvl[c] = 0; mIe[c] = 0; mPerOn[c] = 0; mF32[c] = 0; mSv[c] = 0;
        mPulse[c] = 0; mCmp[c] = 0; mPeriod[c] = 0;
      end
    end else begin
      for (int c = 0; c < NCH; c++)
        hitA[c] = mEn && (mCmp[c] == mCnt[31:0]) && (mF32[c] || mCnt[63:32] == 0);
      for (int c = 0; c < NCH; c++) begin
        mPulse[c] = hitA[c] && !mLvl[c] && mIe[c];
        if (hitA[c] && mLvl[c]) mStat[c] = 1;
        else if (busWe && busAddr == 3 && busWdata[c]) mStat[c] = 0;
        if (busWe && busAddr == 9 + 2*c) begin
          if (!mPerOn[c] || mSv[c]) mCmp[c] = busWdata;
          else mPeriod[c] = busWdata;
          mSv[c] = 0;
        end else if (hitA[c] && mPerOn[c]) begin
          mCmp[c] = mCmp[c] + mPeriod[c];
        end
        if (busWe && busAddr == 8 + 2*c) begin
          mLvl[c] = busWdata[0]; mIe[c] = busWdata[1];
          mPerOn[c] = busWdata[2] && CAPM[c];
          mF32[c] = busWdata[4]; mSv[c] = busWdata[5];
        end
      end
      if (mEn) mCnt = mCnt + 1;
      else begin
        if (busWe && busAddr == 4) mCnt[31:0]  = busWdata;
        if (busWe && busAddr == 5) mCnt[63:32] = busWdata;
      end
      if (busWe && busAddr == 2) mEn = busWdata[0];
    end
  end

  function automatic logic [31:0] mRead(input logic [7:0] a);
    mRead = 32'd0;
    case (a)
      8'd0: mRead = 32'h100 | (NCH - 1);
      8'd1: mRead = TICK;
      8'd2: mRead = {31'b0, mEn};
      8'd3: mRead = {29'b0, mStat};
      8'd4: mRead = mCnt[31:0];
      8'd5: mRead = mCnt[63:32];
      default: begin
        for (int c = 0; c < NCH; c++) begin
          if (a == 8 + 2*c)
            mRead = {26'b0, mSv[c], mF32[c], CAPM[c], mPerOn[c], mIe[c], mLvl[c]};
          if (a == 9 + 2*c) mRead = mCmp[c];
        end
      end
    endcase
  endfunction

  function automatic logic mIrq(input int c);
    mIrq = mLvl[c] ? (mStat[c] && mIe[c]) : mPulse[c];
  endfunction

  // per-clock comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (rstN) begin
      for (int c = 0; c < NCH; c++) begin
        nChecks++;
        if (irq[c] !== mIrq(c)) begin
          nFail++;
          $display("FAIL R9 model irq[%0d]: actual %0b expected %0b", c, irq[c], mIrq(c));
        end
      end
      nChecks++;
      if (busRdata !== mRead(busAddr)) begin
        nFail++;
        $display("FAIL R10 model read @%0d: actual %08h expected %08h",
                 busAddr, busRdata, mRead(busAddr));
      end
    end
  end

  // ---------------- helpers ----------------
  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    busAddr = a; busWe = 1'b1; busWdata = d;
    @(posedge clk); #1;
    busWe = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    busAddr = a; #1;
    d = busRdata;
  endtask

  task automatic idle(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic countHigh(input int c, input int n, output int k);
    k = 0;
    repeat (n) begin @(posedge clk); #1; if (irq[c]) k++; end
  endtask

  task automatic waitIrq(input int c, input int lim, output int cy);
    cy = 0;
    do begin @(posedge clk); #1; cy++; end while (!irq[c] && cy < lim);
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    nChecks++; nFail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  // ---------------- directed sequence ----------------
  initial begin
    logic [31:0] v, a, b, c0;
    int k, cy;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    // R11 reset state
    rd(8'd2, v);  chk("R11 gcfg", v, 0);
    rd(8'd4, v);  chk("R11 counter", v, 0);
    rd(8'd3, v);  chk("R11 flags", v, 0);
    rd(8'd9, v);  chk("R11 match0", v, 0);
    chk("R11 irq", irq, 0);

    // R1 capability words, read-only
    rd(8'd0, v);  chk("R1 info", v, 32'h102);
    rd(8'd1, v);  chk("R1 tick", v, TICK);
    wr(8'd0, 32'hFFFF_FFFF); wr(8'd1, 32'd0);
    rd(8'd0, v);  chk("R1 info after write", v, 32'h102);
    rd(8'd1, v);  chk("R1 tick after write", v, TICK);

    // R10 unmapped words
    rd(8'd6, v);  chk("R10 word6", v, 0);
    rd(8'd7, v);  chk("R10 word7", v, 0);
    rd(8'd14, v); chk("R10 past last channel", v, 0);
    rd(8'd255, v); chk("R10 top word", v, 0);

    // R3 load while stopped, R2 hold while stopped
    wr(8'd5, 32'd0); wr(8'd4, 32'd100);
    rd(8'd4, v);  chk("R3 load stopped", v, 100);
    idle(3);
    rd(8'd4, v);  chk("R2 hold stopped", v, 100);

    // R2 counting
    wr(8'd2, 32'd1);
    rd(8'd4, a); idle(5); rd(8'd4, b);
    chk("R2 five clocks", b - a, 5);
    // R10 counter moves across reads
    rd(8'd4, a); rd(8'd0, v); rd(8'd6, v); idle(1); rd(8'd4, b);
    chk("R10 count during reads", b - a, 1);
    // R3 write ignored while running
    rd(8'd4, a); wr(8'd4, 32'd0); rd(8'd4, b);
    chk("R3 ignored while running", b - a, 1);

    // R5 single-shot edge channel 0
    wr(8'd8, 32'h2);
    rd(8'd4, c0); wr(8'd9, c0 + 20);
    countHigh(0, 40, k);
    chk("R5 one pulse", k, 1);
    rd(8'd9, v);  chk("R5 match kept", v, c0 + 20);

    // R6 repeating edge channel 2
    wr(8'd12, 32'h26);
    rd(8'd12, v); chk("R6 cfg with load-match", v, 32'h2E);
    rd(8'd4, c0); wr(8'd13, c0 + 12);
    rd(8'd12, v); chk("R6 load-match cleared", v, 32'h0E);
    wr(8'd13, 32'd7);
    rd(8'd13, v); chk("R6 match point kept", v, c0 + 12);
    waitIrq(2, 40, cy); chk("R6 first hit", cy < 40, 1);
    waitIrq(2, 40, cy); chk("R6 interval", cy, 7);
    waitIrq(2, 40, cy); chk("R6 interval again", cy, 7);

    // R7 repeat select on non-capable channel 1 (level, enabled)
    wr(8'd10, 32'h7);
    rd(8'd10, v); chk("R7 repeat ignored", v, 32'h3);
    rd(8'd4, c0); wr(8'd11, c0 + 8);
    rd(8'd11, v); chk("R7 match loaded", v, c0 + 8);

    // R8 / R9 level flag and held output
    waitIrq(1, 40, cy); chk("R9 level asserted", cy < 40, 1);
    rd(8'd3, v);  chk("R8 flag set", v, 32'h2);
    countHigh(1, 5, k); chk("R9 level held", k, 5);
    wr(8'd3, 32'h0);
    rd(8'd3, v);  chk("R8 write zero keeps", v, 32'h2);
    wr(8'd3, 32'h5);
    rd(8'd3, v);  chk("R8 other bits keep", v, 32'h2);
    wr(8'd3, 32'h2);
    rd(8'd3, v);  chk("R8 write one clears", v, 32'h0);
    chk("R9 level released", irq[1], 0);

    // R4 stopped counter never hits
    wr(8'd2, 32'd0); wr(8'd5, 32'd0); wr(8'd4, 32'd1010); wr(8'd11, 32'd1010);
    idle(5);
    rd(8'd3, v);  chk("R4 stopped no hit", v, 0);

    // R4 upper half nonzero: low-half-only channel hits, full-width one does not
    wr(8'd8, 32'h12); wr(8'd9, 32'd1010);
    wr(8'd5, 32'd1); wr(8'd4, 32'd1000); wr(8'd2, 32'd1);
    countHigh(0, 30, k);
    chk("R4 low-half compare hits", k, 1);
    rd(8'd3, v);  chk("R4 full compare blocked", v, 0);
    rd(8'd5, v);  chk("R2 upper half", v, 1);

    idle(2);
    summary();
    $finish;
  end
endmodule